// File: doc/BRIEF.md
# Polarity-Aware GPIO Interrupt Front End

This block sits behind a 32-line general-purpose I/O port and turns pad activity into interrupt requests. Each pad input passes through a two-stage synchronizer. A per-pin inversion bit then gives the adjusted input. Level interrupts come straight from the adjusted input. Edge interrupts come from a sticky cause register that records each low-to-high step of the adjusted input. Because one inversion bit serves both paths, it selects high or low level, or rising or falling edge. Software can flip it after each event to follow both edges of a line.

The masked level and edge causes are merged per pin. The 32 pins are then folded into four summary lines, one per group of eight pins, for a higher-level interrupt controller. A simple single-cycle register bus gives access to the output data, direction, inversion, masks and cause. Reads are combinational. A write takes effect at the clock edge where it is presented.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: A value driven on `pad_in` before rising edge k appears in the adjusted input (readable at offset 0x0C for an input pin) after rising edge k+1, and not after edge k alone.
- R2: The adjusted input of a pin is its synchronized pad value XOR its inversion bit (offset 0x08). A 1 inverts the pin. A change of the inversion bit shows in the adjusted input as soon as the write has been clocked.
- R3: A read of offset 0x0C returns, per bit, the adjusted input when the direction bit (offset 0x04) is 1 (input), and the output data bit (offset 0x00) when it is 0. `pad_out` equals the output data register and `pad_oe` is the bitwise inverse of the direction register.
- R4: The level contribution of a pin is adjusted input AND level mask (offset 0x18). It is not latched: it drops as soon as the adjusted input drops.
- R5: A low-to-high step of a pin's adjusted input sets its edge cause bit (offset 0x10) at the next rising edge. With inversion 0 this is a rising pad transition, and with inversion 1 a falling one. The bit then stays set until cleared.
- R6: A write to the inversion register that moves a pin's adjusted input from 0 to 1 also sets that pin's edge cause bit.
- R7: Summary output `irq_sum[g]` is the OR, over pins 8g to 8g+7, of (adjusted input AND level mask) OR (edge cause AND edge mask at offset 0x14).
- R8: A write to offset 0x10 clears every cause bit written as 0 and leaves every bit written as 1 unchanged.
- R9: When a new edge and a clearing write hit the same cause bit in the same cycle, the bit stays set.
- R10: After reset, output data, direction, inversion, both masks and the edge cause are 0, and no summary output is asserted while both masks are 0.
- R11: Output data, direction, inversion and both masks read back what was written. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pad_in | input | 32 | Asynchronous pad inputs |
| pad_out | output | 32 | Output data to the pad drivers |
| pad_oe | output | 32 | Output enable per pin, 1 when the pin is an output |
| irq_sum | output | 4 | Summary interrupt per group of eight pins |

## Verification
A pad change becomes visible in the adjusted input and in the level interrupt two rising edges later. It reaches the edge cause and the edge interrupt on the third. A register write is visible one edge after it is presented, and an edge created by an inversion write lands one edge after that. The bench changes every stimulus on a falling edge and counts falling edges before each comparison. It checks the value just before it is due as well as the value once due, so a stage gained or lost in the path is reported. Each expected value goes into a scoreboard queue and is compared a nanosecond later, well clear of the next rising edge.

// File: rtl/gpio_irq_pkg.sv
// Package: shared sizes and the register offsets of the GPIO interrupt front end.
// Assumes word-aligned byte offsets, decoded on the full address.
package gpio_irq_pkg;
    parameter int PORT_W  = 32;
    parameter int GROUP_W = 8;
    parameter int ADDR_W  = 5;
    localparam int NUM_GROUPS = PORT_W / GROUP_W;

    typedef enum logic [ADDR_W-1:0] {
        OFS_DOUT   = 5'h00,
        OFS_DIR    = 5'h04,
        OFS_INV    = 5'h08,
        OFS_LINE   = 5'h0C,
        OFS_CAUSE  = 5'h10,
        OFS_EMASK  = 5'h14,
        OFS_LMASK  = 5'h18
    } reg_ofs_e;
endpackage

// File: rtl/gpio_sync2.sv
// Module: two-flop synchronizer for a vector of asynchronous pad inputs.
// Assumes each bit is independent; no multi-bit coherence is provided.
module gpio_sync2 #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;
    logic [1:0]       warm_q;

    // Two capture stages toward the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_in;
            stage2_q <= stage1_q;
        end
    end

    // Cycles since reset, saturating, used only to qualify the latency check.
    always_ff @(posedge clk) begin
        if (!rst_n)             warm_q <= 2'd0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    assign q_out = stage2_q;

    // R1: output is the input seen two edges earlier.
    assert_sync_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (q_out == $past(d_in, 2)));
endmodule

// File: rtl/gpio_edge_cause.sv
// Module: per-pin rising-step detector on the adjusted input with a sticky
// cause register that software clears by writing 0s. Assumes the adjusted
// input is already synchronous to clk.
module gpio_edge_cause #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_in,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] clr_keep,
    output logic [WIDTH-1:0] cause
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] cause_q;
    logic [WIDTH-1:0] step_up;
    logic [WIDTH-1:0] keep_mask;

    // Remember the adjusted input one clock back.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level_in;
    end

    // A bit is stepping up when it is 1 now and was 0 one clock earlier.
    always_comb step_up = level_in & ~prev_q;

    // Bits written 0 are dropped; bits written 1 survive.
    always_comb keep_mask = clr_en ? clr_keep : '1;

    // Sticky cause: a new step outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (cause_q & keep_mask) | step_up;
    end

    assign cause = cause_q;

    // R5 and R9: every step is recorded on the next edge, even under a clear.
    assert_step_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up != '0) |=> ((cause & $past(step_up)) == $past(step_up)));

    // R8: bits written 0 with no new step are gone after the write.
    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((cause & ~$past(clr_keep) & ~$past(step_up)) == '0));
endmodule

// File: rtl/gpio_irq_reduce.sv
// Module: merges masked level and edge causes per pin and ORs each group of
// pins into one summary line. Assumes WIDTH is a multiple of GROUP_W.
module gpio_irq_reduce #(
    parameter int WIDTH   = 32,
    parameter int GROUP_W = 8,
    localparam int GROUPS = WIDTH / GROUP_W
) (
    input  logic [WIDTH-1:0]  level_in,
    input  logic [WIDTH-1:0]  level_mask,
    input  logic [WIDTH-1:0]  edge_cause,
    input  logic [WIDTH-1:0]  edge_mask,
    output logic [GROUPS-1:0] summary
);
    logic [WIDTH-1:0] pin_req;

    // Per-pin request from either path.
    always_comb pin_req = (level_in & level_mask) | (edge_cause & edge_mask);

    for (genvar g = 0; g < GROUPS; g++) begin : g_group
        // One summary line per group of pins.
        assign summary[g] = |pin_req[g*GROUP_W +: GROUP_W];
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
// Module: top of the GPIO interrupt front end. Holds the software registers,
// decodes the single-cycle register bus, applies input inversion and feeds
// the edge and reduction stages. Assumes a read needs no side effects and a
// write is taken at the edge where bus_sel and bus_wr are high.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int WIDTH   = PORT_W,
    parameter int GROUP_W = gpio_irq_pkg::GROUP_W,
    parameter int AW      = ADDR_W,
    localparam int GROUPS = WIDTH / GROUP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [GROUPS-1:0] irq_sum
);
    logic [WIDTH-1:0] dout_q, dir_q, inv_q, emask_q, lmask_q;
    logic [WIDTH-1:0] pad_sync;
    logic [WIDTH-1:0] adj_in;
    logic [WIDTH-1:0] cause;
    logic [WIDTH-1:0] line_val;
    logic             wr_en;
    logic             cause_wr;

    // Write strobe for the whole register file.
    always_comb wr_en = bus_sel && bus_wr;
    always_comb cause_wr = wr_en && (bus_addr == OFS_CAUSE);

    gpio_sync2 #(.WIDTH(WIDTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pad_in),
        .q_out (pad_sync)
    );

    // Inversion stage shared by the level and edge paths.
    always_comb adj_in = pad_sync ^ inv_q;

    // Software-written control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q  <= '0;
            dir_q   <= '0;
            inv_q   <= '0;
            emask_q <= '0;
            lmask_q <= '0;
        end else if (wr_en) begin
            case (bus_addr)
                OFS_DOUT:  dout_q  <= bus_wdata;
                OFS_DIR:   dir_q   <= bus_wdata;
                OFS_INV:   inv_q   <= bus_wdata;
                OFS_EMASK: emask_q <= bus_wdata;
                OFS_LMASK: lmask_q <= bus_wdata;
                default:   ;
            endcase
        end
    end

    gpio_edge_cause #(.WIDTH(WIDTH)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (adj_in),
        .clr_en   (cause_wr),
        .clr_keep (bus_wdata),
        .cause    (cause)
    );

    gpio_irq_reduce #(.WIDTH(WIDTH), .GROUP_W(GROUP_W)) u_reduce (
        .level_in   (adj_in),
        .level_mask (lmask_q),
        .edge_cause (cause),
        .edge_mask  (emask_q),
        .summary    (irq_sum)
    );

    // Per-pin read value: adjusted input for inputs, driven data for outputs.
    always_comb line_val = (dir_q & adj_in) | (~dir_q & dout_q);

    // Combinational read mux.
    always_comb begin
        case (bus_addr)
            OFS_DOUT:  bus_rdata = dout_q;
            OFS_DIR:   bus_rdata = dir_q;
            OFS_INV:   bus_rdata = inv_q;
            OFS_LINE:  bus_rdata = line_val;
            OFS_CAUSE: bus_rdata = cause;
            OFS_EMASK: bus_rdata = emask_q;
            OFS_LMASK: bus_rdata = lmask_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign pad_out = dout_q;
    assign pad_oe  = ~dir_q;

    // R10: with both masks clear no summary line may be raised.
    assert_quiet_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((lmask_q == '0) && (emask_q == '0)) |-> (irq_sum == '0));

    // R4: a masked high adjusted input always shows on its group line.
    assert_level_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((adj_in[7:0] & lmask_q[7:0]) != '0) |-> irq_sum[0]);
endmodule

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic [3:0]  irq_sum;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        int          kind;   // 0 read data, 1 summary, 2 pad_out, 3 pad_oe
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];
    event  mon_go;

    gpio_irq_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq_sum   (irq_sum)
    );

    always #5 clk = ~clk;

    // Monitor: pops one expected item per request and compares.
    initial begin
        forever begin
            item_t it;
            logic [31:0] obs;
            @(mon_go);
            #1;
            it = sb_q.pop_front();
            case (it.kind)
                0:       obs = bus_rdata;
                1:       obs = {28'd0, irq_sum};
                2:       obs = pad_out;
                default: obs = pad_oe;
            endcase
            checks++;
            if (obs !== it.exp) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", it.tag, obs, it.exp);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sb_q.push_back(it);
        ->mon_go;
        #2;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        push(0, exp, tag);
        bus_sel = 1'b0;
    endtask

    task automatic irq(input logic [3:0] exp, input string tag);
        push(1, {28'd0, exp}, tag);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #2000000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all): actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R10: reset state.
        rd(5'h00, 32'h0, "R10 dout reset");
        rd(5'h04, 32'h0, "R10 dir reset");
        rd(5'h08, 32'h0, "R10 inv reset");
        rd(5'h10, 32'h0, "R10 cause reset");
        rd(5'h14, 32'h0, "R10 emask reset");
        rd(5'h18, 32'h0, "R10 lmask reset");
        irq(4'h0, "R10 summary reset");

        // R11 readback, R3 pad ports.
        wr(5'h00, 32'hA5A50F0F);
        wr(5'h04, 32'hFFFF0000);
        wr(5'h14, 32'h9ABCDEF0);
        wr(5'h18, 32'h12345678);
        rd(5'h00, 32'hA5A50F0F, "R11 dout readback");
        rd(5'h04, 32'hFFFF0000, "R11 dir readback");
        rd(5'h14, 32'h9ABCDEF0, "R11 emask readback");
        rd(5'h18, 32'h12345678, "R11 lmask readback");
        rd(5'h1C, 32'h0, "R11 unmapped reads zero");
        push(2, 32'hA5A50F0F, "R3 pad_out");
        push(3, 32'h0000FFFF, "R3 pad_oe");
        wr(5'h14, 32'h0);
        wr(5'h18, 32'h0);

        // R3: mixed direction read of the line register.
        pad_in = 32'h12345678;
        step(2);
        rd(5'h0C, 32'h12340F0F, "R3 mixed line read");
        wr(5'h00, 32'h0);
        wr(5'h04, 32'hFFFFFFFF);
        push(3, 32'h0, "R3 pad_oe all inputs");

        // R1: two-edge latency.
        pad_in = 32'h000000FF;
        step(1);
        rd(5'h0C, 32'h12345678, "R1 not yet after one edge");
        step(1);
        rd(5'h0C, 32'h000000FF, "R1 visible after two edges");
        step(4);
        wr(5'h10, 32'h0);
        rd(5'h10, 32'h0, "R8 full clear");

        // R2 and R6: inversion write.
        wr(5'h08, 32'h0000FFFF);
        rd(5'h08, 32'h0000FFFF, "R11 inv readback");
        rd(5'h0C, 32'h0000FF00, "R2 inverted line");
        rd(5'h10, 32'h0, "R6 cause not yet");
        step(1);
        rd(5'h10, 32'h0000FF00, "R6 inversion makes edge");
        wr(5'h08, 32'h0);
        step(3);
        wr(5'h10, 32'h0);
        rd(5'h10, 32'h0, "R8 clear again");

        // R5: rising with inversion 0, falling with inversion 1.
        pad_in = 32'h000100FF;
        step(3);
        wr(5'h08, 32'h00010000);
        step(2);
        wr(5'h10, 32'h0);
        rd(5'h10, 32'h0, "R5 setup clear");
        pad_in = 32'h000001FF;
        step(2);
        rd(5'h10, 32'h0, "R5 cause not before third edge");
        step(1);
        rd(5'h10, 32'h00010100, "R5 rise and fall captured");
        pad_in = 32'h000100FF;
        step(4);
        rd(5'h10, 32'h00010100, "R5 sticky");

        // R8: write 0 clears only that bit.
        wr(5'h10, 32'hFFFFFEFF);
        rd(5'h10, 32'h00010000, "R8 partial clear");

        // R9: edge and clear in the same cycle.
        pad_in = 32'h010100FF;
        step(2);
        wr(5'h10, 32'h0);
        rd(5'h10, 32'h01000000, "R9 edge beats clear");
        wr(5'h10, 32'h0);
        rd(5'h10, 32'h0, "R9 later clear");

        // R4: level path, unlatched.
        wr(5'h18, 32'h000000F0);
        irq(4'h1, "R4 level raised");
        pad_in = 32'h01010000;
        step(1);
        irq(4'h1, "R4 still high one edge later");
        step(1);
        irq(4'h0, "R4 drops with input");

        // R7: edge path and group folding.
        wr(5'h18, 32'h0);
        wr(5'h14, 32'hFFFFFFFF);
        irq(4'h0, "R7 no cause no irq");
        pad_in = 32'h01110000;
        step(2);
        irq(4'h0, "R7 edge irq not yet");
        step(1);
        irq(4'h4, "R7 edge irq group 2");
        wr(5'h18, 32'h01000000);
        irq(4'hC, "R7 level adds group 3");
        wr(5'h14, 32'h0);
        irq(4'h8, "R7 edge masked off");
        wr(5'h18, 32'h0);
        irq(4'h0, "R10 masks zero quiet");
        rd(5'h10, 32'h00100000, "R7 cause kept while masked");

        step(2);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule